// File: doc/BRIEF.md
# PCM Time-Slot Serial Port

This block is the digital serial interface of a voice codec that shares a time-division multiplexed backplane with other devices. In every frame it sends one 8-bit PCM sample and takes in one 8-bit PCM sample. Each direction has its own frame sync. All timing comes from the bit clock. The transmit side shifts bits out on rising edges. The receive side samples bits on falling edges.

The mode input selects one of two slot placements:

- **Non-delayed:** the frame sync marks this device's own slot, which is always slot 0.
- **Delayed:** the frame sync marks the start of the whole frame. An internal bit counter then finds the programmed slot number, separately for transmit and receive.

Each direction has two data lines. A port select chooses which line is used in a frame. While the transmit slot is active, the block enables the chosen output line and pulls that line's active-low slot strobe low. The strobe can be used to enable a backplane line driver. The high-impedance state is shown as an output-enable per line, and the open-drain strobe is shown as released-high. A received byte appears on a parallel output together with a one-period valid pulse.

Top module: `pcm_tslot_port`

## Requirements
- R1: While `rst_ni` is low and until the first frame sync, both `tx_oe_o` bits are 0, both `tx_slot_n_o` bits are 1, `tx_data_o` is 0, `rx_valid_o` is 0 and `rx_byte_o` is 0.
- R2: A transmit frame starts at rising bit-clock edge E0, where `tx_fs_i` is sampled high after having been sampled low. Bit k of the frame (k = 0 upward) is driven from edge E(k+1) until edge E(k+2). Slot s covers frame bits 8s to 8s+7, and the MSB (byte bit 7) is sent first.
- R3: When `delayed_mode_i` = 0, the transmit slot is slot 0 and `tx_slot_i` has no effect. When `delayed_mode_i` = 1, the transmit slot is `tx_slot_i`, which ranges from 0 to SLOTS-1.
- R4: Port select value p (0 or 1) means line p. Only line p has its `tx_oe_o` bit set, and it is set only during the slot. The `tx_slot_n_o` bit of a line is 0 exactly while that line's `tx_oe_o` bit is 1.
- R5: Outside the active slot, all `tx_oe_o` bits are 0, all strobes are 1, and `tx_data_o` is 0 on every line that is not enabled.
- R6: `tx_byte_i` and `tx_port_i` are captured at the edge where the slot begins. Changes made during a slot take effect only in the next frame.
- R7: A receive frame starts at falling edge F0, where `rx_fs_i` is sampled high after having been sampled low. Frame bit k is sampled at falling edge F(k+1) from the line selected by `rx_port_i`, MSB first. The slot is chosen by `rx_slot_i` and the mode in the same way as in R3.
- R8: From the falling edge that samples the eighth bit of the receive slot, `rx_byte_o` holds the assembled byte and `rx_valid_o` is 1 for exactly one bit period.
- R9: Data on the receive lines outside the slot, and data on the line that is not selected, does not change `rx_byte_o` and causes no `rx_valid_o` pulse.
- R10: Only a rising edge of a sync starts a frame. A sync held high (squarewave) does not restart the frame. After SLOTS×8 bits the frame ends, and no slot becomes active again until the next sync edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| delayed_mode_i | input | 1 | 0: sync marks own slot; 1: sync marks frame start |
| tx_fs_i | input | 1 | Transmit frame sync |
| tx_slot_i | input | clog2(SLOTS) | Transmit slot number (delayed mode) |
| tx_port_i | input | 1 | Transmit line select |
| tx_byte_i | input | 8 | Transmit sample holding register |
| tx_data_o | output | 2 | Transmit serial data, one per line |
| tx_oe_o | output | 2 | Transmit output enable per line (0 = high impedance) |
| tx_slot_n_o | output | 2 | Active-low slot strobe per line (1 = released) |
| rx_fs_i | input | 1 | Receive frame sync |
| rx_slot_i | input | clog2(SLOTS) | Receive slot number (delayed mode) |
| rx_port_i | input | 1 | Receive line select |
| rx_data_i | input | 2 | Receive serial data lines |
| rx_byte_o | output | 8 | Last received sample |
| rx_valid_o | output | 1 | One-period pulse when a new sample is complete |

## Verification
A wrong bit-position counter or a wrong start lag moves the transmit enable window by whole bit periods, or shifts the serialized byte by one bit. Either fault appears on the data and strobe pins within the first frame. A stale or wrongly latched port or byte shows up as data on the wrong line, or as a changed byte in the middle of a slot. Checking every cycle of each frame catches this during the slot in which it happens. On the receive side, a wrong sampling position or a leak from the unselected line corrupts the byte shown at the next valid pulse. A missed end of frame shows up as a second slot with no sync before it.

// File: rtl/pcm_tslot_pkg.sv
package pcm_tslot_pkg;
  localparam int SAMPLE_W = 8;
  localparam int BIT_IDX_W = $clog2(SAMPLE_W);
  typedef logic [SAMPLE_W-1:0] pcm_sample_t;
  typedef logic [BIT_IDX_W-1:0] bit_idx_t;
endpackage

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer
  import pcm_tslot_pkg::*;
#(
  parameter int SLOTS     = 32,
  parameter bit START_LAG = 1'b0,
  localparam int SLOT_W   = $clog2(SLOTS),
  localparam int POS_W    = SLOT_W + BIT_IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fs_i,
  input  logic              delayed_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic              hit_o,
  output bit_idx_t          bit_o,
  output logic              slot_load_o
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(SLOTS * SAMPLE_W - 1);

  logic             fs_q, run_q, run_n, start, go;
  logic [POS_W-1:0] pos_q, pos_n;
  logic [SLOT_W-1:0] target;

  assign start = fs_i & ~fs_q;

  // transmit side waits one edge after the sync is sampled
  if (START_LAG) begin : g_lag
    logic pend_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q <= 1'b0;
      else         pend_q <= start;
    end
    assign go = pend_q;
  end else begin : g_direct
    assign go = start;
  end

  always_comb begin
    run_n = run_q;
    pos_n = pos_q;
    if (go) begin
      run_n = 1'b1;
      pos_n = '0;
    end else if (run_q) begin
      if (pos_q == LAST_POS) run_n = 1'b0;
      else                   pos_n = pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_q  <= 1'b0;
      run_q <= 1'b0;
      pos_q <= '0;
    end else begin
      fs_q  <= fs_i;
      run_q <= run_n;
      pos_q <= pos_n;
    end
  end

  assign target      = delayed_i ? slot_i : '0;
  assign hit_o       = run_q && (pos_q[POS_W-1:BIT_IDX_W] == target);
  assign bit_o       = pos_q[BIT_IDX_W-1:0];
  assign slot_load_o = run_n && (pos_n == {target, {BIT_IDX_W{1'b0}}});
endmodule

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane
  import pcm_tslot_pkg::*;
#(
  parameter int PORTS   = 2,
  localparam int PSEL_W = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  bit_idx_t          bit_i,
  input  logic              load_i,
  input  pcm_sample_t       byte_i,
  input  logic [PSEL_W-1:0] port_i,
  output logic [PORTS-1:0]  oe_o,
  output logic [PORTS-1:0]  data_o
);
  pcm_sample_t       hold_q;
  logic [PSEL_W-1:0] port_q;
  logic              cur_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      port_q <= '0;
    end else if (load_i) begin
      hold_q <= byte_i;
      port_q <= port_i;
    end
  end

  assign cur_bit = hold_q[BIT_IDX_W'(SAMPLE_W - 1) - bit_i];

  for (genvar p = 0; p < PORTS; p++) begin : g_line
    assign oe_o[p]   = hit_i && (port_q == PSEL_W'(p));
    assign data_o[p] = oe_o[p] & cur_bit;
  end
endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane
  import pcm_tslot_pkg::*;
#(
  parameter int PORTS   = 2,
  localparam int PSEL_W = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  bit_idx_t          bit_i,
  input  logic [PSEL_W-1:0] port_i,
  input  logic [PORTS-1:0]  data_i,
  output pcm_sample_t       byte_o,
  output logic              valid_o
);
  logic [PSEL_W-1:0] port_q, sel;
  pcm_sample_t       shift_q, byte_q;
  logic              valid_q, din;

  // line choice fixed at the first bit of the slot
  assign sel = (bit_i == '0) ? port_i : port_q;
  assign din = data_i[sel];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      port_q  <= '0;
      shift_q <= '0;
      byte_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (hit_i) begin
        port_q  <= sel;
        shift_q <= {shift_q[SAMPLE_W-2:0], din};
        if (bit_i == BIT_IDX_W'(SAMPLE_W - 1)) begin
          byte_q  <= {shift_q[SAMPLE_W-2:0], din};
          valid_q <= 1'b1;
        end
      end
    end
  end

  assign byte_o  = byte_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/pcm_tslot_port.sv
module pcm_tslot_port
  import pcm_tslot_pkg::*;
#(
  parameter int SLOTS   = 32,
  parameter int PORTS   = 2,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int PSEL_W = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic              bclk_i,
  input  logic              rst_ni,
  input  logic              delayed_mode_i,
  input  logic              tx_fs_i,
  input  logic [SLOT_W-1:0] tx_slot_i,
  input  logic [PSEL_W-1:0] tx_port_i,
  input  logic [7:0]        tx_byte_i,
  output logic [PORTS-1:0]  tx_data_o,
  output logic [PORTS-1:0]  tx_oe_o,
  output logic [PORTS-1:0]  tx_slot_n_o,
  input  logic              rx_fs_i,
  input  logic [SLOT_W-1:0] rx_slot_i,
  input  logic [PSEL_W-1:0] rx_port_i,
  input  logic [PORTS-1:0]  rx_data_i,
  output logic [7:0]        rx_byte_o,
  output logic              rx_valid_o
);
  logic     tx_hit, tx_load, rx_hit, rx_load_unused, bclk_n;
  bit_idx_t tx_bit, rx_bit;

  assign bclk_n = ~bclk_i;

  pcm_frame_timer #(.SLOTS(SLOTS), .START_LAG(1'b1)) u_tx_timer (
    .clk_i(bclk_i), .rst_ni(rst_ni), .fs_i(tx_fs_i), .delayed_i(delayed_mode_i),
    .slot_i(tx_slot_i), .hit_o(tx_hit), .bit_o(tx_bit), .slot_load_o(tx_load)
  );

  pcm_tx_lane #(.PORTS(PORTS)) u_tx_lane (
    .clk_i(bclk_i), .rst_ni(rst_ni), .hit_i(tx_hit), .bit_i(tx_bit),
    .load_i(tx_load), .byte_i(tx_byte_i), .port_i(tx_port_i),
    .oe_o(tx_oe_o), .data_o(tx_data_o)
  );

  // open-drain strobe: 1 models the released state
  assign tx_slot_n_o = ~tx_oe_o;

  pcm_frame_timer #(.SLOTS(SLOTS), .START_LAG(1'b0)) u_rx_timer (
    .clk_i(bclk_n), .rst_ni(rst_ni), .fs_i(rx_fs_i), .delayed_i(delayed_mode_i),
    .slot_i(rx_slot_i), .hit_o(rx_hit), .bit_o(rx_bit), .slot_load_o(rx_load_unused)
  );

  pcm_rx_lane #(.PORTS(PORTS)) u_rx_lane (
    .clk_i(bclk_n), .rst_ni(rst_ni), .hit_i(rx_hit), .bit_i(rx_bit),
    .port_i(rx_port_i), .data_i(rx_data_i), .byte_o(rx_byte_o), .valid_o(rx_valid_o)
  );
endmodule

// File: rtl/pcm_tslot_port_chk.sv
module pcm_tslot_port_chk #(
  parameter int SLOTS   = 32,
  parameter int PORTS   = 2,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input logic              bclk_i,
  input logic              rst_ni,
  input logic              delayed_mode_i,
  input logic              tx_fs_i,
  input logic [SLOT_W-1:0] tx_slot_i,
  input logic [PORTS-1:0]  tx_oe_o,
  input logic [PORTS-1:0]  tx_slot_n_o,
  input logic [PORTS-1:0]  tx_data_o,
  input logic              rx_valid_o
);
  a_r4_one_line: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    $onehot0(tx_oe_o));

  a_r4_strobe_follows_enable: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    tx_slot_n_o == ~tx_oe_o);

  a_r5_quiet_when_disabled: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    (tx_data_o & ~tx_oe_o) == '0);

  a_r6_line_held_in_slot: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    ($rose(|tx_oe_o) && !($past(tx_fs_i) && !$past(tx_fs_i, 2)) &&
     $stable(tx_slot_i) && $stable(delayed_mode_i))
    |=> (!$stable(tx_slot_i) || !$stable(delayed_mode_i) || $stable(tx_oe_o)));

  a_r8_single_pulse: assert property (@(negedge bclk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
endmodule

bind pcm_tslot_port pcm_tslot_port_chk #(.SLOTS(SLOTS), .PORTS(PORTS)) u_chk (
  .bclk_i(bclk_i), .rst_ni(rst_ni), .delayed_mode_i(delayed_mode_i),
  .tx_fs_i(tx_fs_i), .tx_slot_i(tx_slot_i), .tx_oe_o(tx_oe_o),
  .tx_slot_n_o(tx_slot_n_o), .tx_data_o(tx_data_o), .rx_valid_o(rx_valid_o)
);

// File: tb/pcm_tslot_port_test.sv
`timescale 1ns/1ps
module pcm_tslot_port_test;
  localparam int SLOTS  = 4;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int NBITS  = SLOTS * 8;

  logic bclk_i = 1'b0, rst_ni = 1'b0, delayed_mode_i = 1'b0;
  logic tx_fs_i = 1'b0, rx_fs_i = 1'b0;
  logic [SLOT_W-1:0] tx_slot_i = '0, rx_slot_i = '0;
  logic tx_port_i = 1'b0, rx_port_i = 1'b0;
  logic [7:0] tx_byte_i = '0;
  logic [1:0] rx_data_i = '0;
  logic [1:0] tx_data_o, tx_oe_o, tx_slot_n_o;
  logic [7:0] rx_byte_o;
  logic rx_valid_o;

  int checks = 0, fails = 0;

  always #5 bclk_i = ~bclk_i;

  pcm_tslot_port #(.SLOTS(SLOTS), .PORTS(2)) uut (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // {oe, strobe_n, data} expected after edge E_k
  function automatic logic [5:0] tx_exp(input logic mode, input int slot, input int port,
                                        input logic [7:0] b, input int k);
    int es;
    logic [1:0] oe, d;
    es = mode ? slot : 0;
    oe = '0;
    d  = '0;
    if (k >= 1 && k <= NBITS && ((k - 1) / 8) == es) begin
      oe[port] = 1'b1;
      d[port]  = b[7 - ((k - 1) % 8)];
    end
    return {oe, ~oe, d};
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge bclk_i);
    #2;
  endtask

  task automatic tx_frame(input logic mode, input int slot, input int port, input logic [7:0] b,
                          input int chg_k, input int port2, input logic [7:0] b2, input bit square,
                          input string req);
    delayed_mode_i = mode;
    tx_slot_i = SLOT_W'(slot);
    tx_port_i = port[0];
    tx_byte_i = b;
    @(posedge bclk_i); #2;
    tx_fs_i = 1'b1;
    for (int k = 0; k <= NBITS + 3; k++) begin
      logic [5:0] e;
      @(posedge bclk_i); #2;
      e = tx_exp(mode, slot, port, b, k);
      check({tx_oe_o, tx_slot_n_o, tx_data_o} == e, req, {tx_oe_o, tx_slot_n_o, tx_data_o}, e);
      if ((!square && k == 0) || (square && k == 16)) tx_fs_i = 1'b0;
      if (k == chg_k) begin
        tx_port_i = port2[0];
        tx_byte_i = b2;
      end
    end
    tx_fs_i = 1'b0;
    idle(3);
  endtask

  task automatic rx_frame(input logic mode, input int slot, input int port, input logic [7:0] b,
                          input string req);
    int es, k_valid;
    logic [7:0] prev;
    es = mode ? slot : 0;
    k_valid = es * 8 + 9;
    prev = rx_byte_o;
    delayed_mode_i = mode;
    rx_slot_i = SLOT_W'(slot);
    rx_port_i = port[0];
    @(posedge bclk_i); #2;
    rx_fs_i = 1'b1;
    for (int k = 1; k <= NBITS + 3; k++) begin
      logic [1:0] d;
      @(posedge bclk_i); #2;
      if (k == 1) rx_fs_i = 1'b0;
      // valid/byte as left by falling edge F(k-1)
      check(rx_valid_o == (k == k_valid), req, {31'd0, rx_valid_o}, {31'd0, k == k_valid});
      if (k >= k_valid) check(rx_byte_o == b, req, {24'd0, rx_byte_o}, {24'd0, b});
      else              check(rx_byte_o == prev, "R9", {24'd0, rx_byte_o}, {24'd0, prev});
      // noise everywhere, true bit on the selected line in the slot
      d = {~b[k % 8], b[(k + 3) % 8]};
      if (k >= 1 && k <= NBITS && ((k - 1) / 8) == es) d[port] = b[7 - ((k - 1) % 8)];
      else if (k <= NBITS) d = ~{b[7 - ((k - 1) % 8)], b[7 - ((k - 1) % 8)]};
      rx_data_i = d;
    end
    idle(3);
  endtask

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0t expected=done", $time);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #3;
    check({tx_oe_o, tx_slot_n_o, tx_data_o, rx_valid_o, rx_byte_o} == {6'b001100, 1'b0, 8'h00},
          "R1", {tx_oe_o, tx_slot_n_o, tx_data_o, rx_valid_o, rx_byte_o}, {6'b001100, 9'h0});
    #19 rst_ni = 1'b1;
    idle(4);
    check({tx_oe_o, tx_slot_n_o, tx_data_o, rx_valid_o, rx_byte_o} == {6'b001100, 1'b0, 8'h00},
          "R1", {tx_oe_o, tx_slot_n_o, tx_data_o, rx_valid_o, rx_byte_o}, {6'b001100, 9'h0});

    // R2 R3 R4 R5: sweep of mode, line and slot
    for (int m = 0; m < 2; m++)
      for (int p = 0; p < 2; p++)
        for (int s = 0; s < SLOTS; s++)
          tx_frame(m[0], s, p, 8'(8'hA5 ^ (s * 37 + p * 11 + m * 3)), -1, 0, 8'h00, 1'b0,
                   m ? "R3 R4 R2" : "R2 R3 R5");

    // R6: mid-slot change of byte and line
    tx_frame(1'b1, 2, 0, 8'h3C, 19, 1, 8'hC3, 1'b0, "R6");
    tx_frame(1'b1, 2, 1, 8'hC3, -1, 1, 8'hC3, 1'b0, "R6");

    // R10: squarewave sync, then no repeat without a sync
    tx_frame(1'b1, 1, 0, 8'h96, -1, 0, 8'h00, 1'b1, "R10");
    tx_frame(1'b0, 3, 1, 8'h69, -1, 1, 8'h69, 1'b1, "R10");
    for (int i = 0; i < 40; i++) begin
      @(posedge bclk_i); #2;
      check(tx_oe_o == 2'b00 && tx_slot_n_o == 2'b11, "R10", {tx_oe_o, tx_slot_n_o}, 4'b0011);
    end

    // R7 R8 R9: receive sweep
    for (int m = 0; m < 2; m++)
      for (int p = 0; p < 2; p++)
        for (int s = 0; s < SLOTS; s++)
          rx_frame(m[0], s, p, 8'(8'h5A + s * 29 + p * 70 + m * 13), "R7 R8");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule